// File: doc/BRIEF.md
# Edge-Race Frequency Comparator

This block decides which of two square waves runs faster: a locally synthesized reference, or an unknown input. Both waves are free of any clock domain. Each is resynchronized to a fast system clock and turned into one-cycle rising-edge pulses. Two small edge counters then race each other. Each counter counts the rising edges of its own wave. A rising edge of the opposite wave clears it, so every counter measures one period of the other wave at a time.

When a counter collects two of its own edges inside one period of the other wave, it writes a set/reset style flag. The reference counter sets the flag ("reference is faster"). The unknown counter clears it ("unknown is faster"). The flag holds between writes.

Every write produces a one-cycle decision strobe. A sticky lock bit tells the user that at least one write has happened since reset. Before that first write the flag carries no meaning. In a frequency-locking loop the flag drives the up/down direction of the synthesizer's tuning word. When the two frequencies are close, the flag keeps flipping between the two states and never settles.

Top module: `freq_race_cmp`

## Requirements
- R1: After reset, `ref_faster`, `decision_vld` and `locked` are all 0.
- R2: Two rising edges of `ref_wave` inside one period of `unk_wave` set `ref_faster` to 1 and pulse `decision_vld`. The period is a closed interval between two consecutive rising edges of `unk_wave`. An edge that coincides with an edge of `unk_wave` closes the old period and also counts as the first edge of the new one.
- R3: The same rule with the roles swapped: two rising edges of `unk_wave` inside one period of `ref_wave` clear `ref_faster` to 0 and pulse `decision_vld`.
- R4: `ref_faster` keeps its value between writes. A later decision in the opposite direction overwrites it, so a change in which wave dominates is followed by a change of the flag.
- R5: If both counters reach two edges in the same clock cycle, `ref_faster` keeps its previous value and `decision_vld` stays 0. Two phase-aligned waves of equal frequency therefore never produce a decision.
- R6: `decision_vld` is high for exactly one cycle per write and is never high in two consecutive cycles.
- R7: `locked` is 0 until the first `decision_vld`. It rises together with that strobe and stays at 1 until reset.
- R8: With the default two-flop synchronizer, `decision_vld` and the new flag value appear after the third rising clock edge following the first clock edge that samples the deciding input edge high. They are not visible after the second.
- R9: A counter saturates at two. Further edges of its own wave before the next edge of the other wave produce no further `decision_vld`.
- R10: For steady periodic waves with different periods, every decision reports the faster wave, and at least one decision is made within a few periods of the slower wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_wave | input | 1 | Synthesized reference square wave, asynchronous |
| unk_wave | input | 1 | Unknown square wave, asynchronous |
| ref_faster | output | 1 | 1: reference faster, 0: unknown faster |
| decision_vld | output | 1 | One-cycle strobe on every write of `ref_faster` |
| locked | output | 1 | Sticky: at least one decision since reset |

## Verification
A set request and a clear request can arrive in the same cycle. This happens only when both counters already hold one edge and both waves rise on the same sampled clock edge. The bench provokes this with simultaneous pulses on both inputs, both from a fresh reset and after the flag has been set. In both cases it checks that the strobe stays low and the flag keeps its value. A sweep with equal, phase-aligned periods must leave `locked` at 0. The unequal sweep points in the same sweep must lock onto the faster wave.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    // Channel indices shared by the top level and its checker
    localparam int CH_REF = 0;
    localparam int CH_UNK = 1;
    localparam int N_CH   = 2;

    // Registered decision state of the top level
    typedef struct packed {
        logic flag;    // 1: reference faster
        logic vld;     // write strobe
        logic locked;  // sticky first-write marker
    } dec_state_t;

    localparam dec_state_t DEC_RESET = '{flag: 1'b0, vld: 1'b0, locked: 1'b0};

endpackage

// File: rtl/fcmp_edge_det.sv
module fcmp_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wave_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_d, sync_q;
    logic              last_d, last_q;
    logic              rise_d, rise_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], wave_i};
        last_d = sync_q[STAGES-1];
        rise_d = sync_q[STAGES-1] & ~last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
            rise_q <= rise_d;
        end
    end

    assign rise_o = rise_q;

endmodule

// File: rtl/fcmp_edge_cnt.sv
module fcmp_edge_cnt #(
    parameter int HITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic own_rise_i,
    input  logic other_rise_i,
    output logic hit_o
);

    localparam int CW = $clog2(HITS + 1);
    localparam logic [CW-1:0] LAST_BEFORE_HIT = CW'(HITS - 1);
    localparam logic [CW-1:0] SAT_VAL         = CW'(HITS);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          hit_d;

    always_comb begin
        // The edge that reaches the threshold fires, even if it coincides with a period boundary
        hit_d = own_rise_i && (cnt_q == LAST_BEFORE_HIT);
        cnt_d = cnt_q;
        if (other_rise_i) begin
            // New period of the other wave; a coincident own edge opens it
            cnt_d = own_rise_i ? CW'(1) : '0;
        end else if (own_rise_i && (cnt_q < SAT_VAL)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit_o = hit_d;

endmodule

// File: rtl/freq_race_cmp.sv
module freq_race_cmp #(
    parameter int SYNC_STAGES = 2,
    parameter int HITS        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_wave,
    input  logic unk_wave,
    output logic ref_faster,
    output logic decision_vld,
    output logic locked
);
    import fcmp_pkg::*;

    logic [N_CH-1:0] wave_vec;
    logic [N_CH-1:0] rise_vec;
    logic [N_CH-1:0] hit_vec;

    assign wave_vec[CH_REF] = ref_wave;
    assign wave_vec[CH_UNK] = unk_wave;

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
        fcmp_edge_det #(.STAGES(SYNC_STAGES)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .wave_i (wave_vec[gi]),
            .rise_o (rise_vec[gi])
        );
        fcmp_edge_cnt #(.HITS(HITS)) u_cnt (
            .clk          (clk),
            .rst_n        (rst_n),
            .own_rise_i   (rise_vec[gi]),
            .other_rise_i (rise_vec[N_CH-1-gi]),
            .hit_o        (hit_vec[gi])
        );
    end

    dec_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        // Exactly one requester writes; a tie leaves the flag untouched
        if (hit_vec[CH_REF] ^ hit_vec[CH_UNK]) begin
            st_d.flag   = hit_vec[CH_REF];
            st_d.vld    = 1'b1;
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= DEC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_faster   = st_q.flag;
    assign decision_vld = st_q.vld;
    assign locked       = st_q.locked;

endmodule

// File: rtl/fcmp_chk.sv
module fcmp_chk (
    input logic clk,
    input logic rst_n,
    input logic hit_ref,
    input logic hit_unk,
    input logic ref_faster,
    input logic decision_vld,
    input logic locked
);

    AST_SET_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ref && !hit_unk) |=> (ref_faster && decision_vld)); // R2

    AST_CLR_ON_UNK: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_unk && !hit_ref) |=> (!ref_faster && decision_vld)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_ref && !hit_unk) |=> ($stable(ref_faster) && !decision_vld)); // R4

    AST_TIE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ref && hit_unk) |=> ($stable(ref_faster) && !decision_vld)); // R5

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        decision_vld |=> !decision_vld); // R6

    AST_LOCK_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        decision_vld |-> locked); // R7

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R7

    AST_LOCK_ONLY_BY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> decision_vld); // R7

endmodule

bind freq_race_cmp fcmp_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_ref      (hit_vec[0]),
    .hit_unk      (hit_vec[1]),
    .ref_faster   (ref_faster),
    .decision_vld (decision_vld),
    .locked       (locked)
);

// File: tb/sim_freq_race_cmp.sv
`timescale 1ns/1ps
module sim_freq_race_cmp;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_w = 1'b0;
    logic unk_w = 1'b0;
    logic ref_faster, decision_vld, locked;

    int n_chk = 0;
    int n_bad = 0;
    int cr = 0;
    int cu = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    freq_race_cmp u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_wave     (ref_w),
        .unk_wave     (unk_w),
        .ref_faster   (ref_faster),
        .decision_vld (decision_vld),
        .locked       (locked)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_w = 1'b0;
        unk_w = 1'b0;
        cr = 0;
        cu = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input bit r, input bit u);
        @(negedge clk);
        ref_w = r;
        unk_w = u;
        @(negedge clk);
        ref_w = 1'b0;
        unk_w = 1'b0;
    endtask

    task automatic count_vld(input int n, output int vc);
        vc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (decision_vld) vc++;
        end
    endtask

    // Square waves with half periods hr/hu (in clock cycles), driven at negedges
    task automatic run_waves(input int hr, input int hu, input int n,
                             input bit chk_each, input bit exp_flag, output int vc);
        vc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (decision_vld) begin
                vc++;
                if (chk_each)
                    chk(ref_faster == exp_flag, "R10 decision names faster wave",
                        ref_faster, exp_flag);
            end
            cr++;
            if (cr >= hr) begin cr = 0; ref_w = ~ref_w; end
            cu++;
            if (cu >= hu) begin cu = 0; unk_w = ~unk_w; end
        end
    endtask

    initial begin
        int vc;
        do_reset();

        // R1 reset state
        @(negedge clk);
        chk(ref_faster == 1'b0, "R1 flag after reset", ref_faster, 0);
        chk(decision_vld == 1'b0, "R1 strobe after reset", decision_vld, 0);
        chk(locked == 1'b0, "R1 lock after reset", locked, 0);

        // One reference edge alone: no decision yet (R7)
        pulse(1'b1, 1'b0);
        count_vld(6, vc);
        chk(vc == 0, "R7 no decision after a single edge", vc, 0);
        chk(locked == 1'b0, "R7 lock still low", locked, 0);

        // Second reference edge: exact latency (R8, R2)
        @(negedge clk);
        ref_w = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ref_w = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(decision_vld == 1'b0, "R8 strobe not yet after two edges", decision_vld, 0);
        @(posedge clk);
        @(negedge clk);
        chk(decision_vld == 1'b1, "R8 strobe after third edge", decision_vld, 1);
        chk(ref_faster == 1'b1, "R2 flag set by reference", ref_faster, 1);
        chk(locked == 1'b1, "R7 lock rises with strobe", locked, 1);
        @(negedge clk);
        chk(decision_vld == 1'b0, "R6 strobe lasts one cycle", decision_vld, 0);

        // Third reference edge in the same period: saturated (R9)
        pulse(1'b1, 1'b0);
        count_vld(8, vc);
        chk(vc == 0, "R9 saturated counter silent", vc, 0);

        // One unknown edge: opens a new period, flag held (R4)
        pulse(1'b0, 1'b1);
        count_vld(8, vc);
        chk(vc == 0, "R4 no write on single unknown edge", vc, 0);
        chk(ref_faster == 1'b1, "R4 flag held", ref_faster, 1);

        // Second unknown edge: clears the flag (R3)
        pulse(1'b0, 1'b1);
        count_vld(8, vc);
        chk(vc == 1, "R3 one strobe on unknown decision", vc, 1);
        chk(ref_faster == 1'b0, "R3 flag cleared by unknown", ref_faster, 0);
        chk(locked == 1'b1, "R7 lock sticky", locked, 1);

        // Simultaneous edges from reset: tie, no decision (R5)
        do_reset();
        pulse(1'b1, 1'b1);
        count_vld(6, vc);
        pulse(1'b1, 1'b1);
        count_vld(8, vc);
        chk(vc == 0, "R5 tie gives no strobe", vc, 0);
        chk(locked == 1'b0, "R5 tie does not lock", locked, 0);

        // Tie after the flag has been set (R5)
        do_reset();
        pulse(1'b1, 1'b0);
        count_vld(4, vc);
        pulse(1'b1, 1'b0);
        count_vld(8, vc);
        chk(ref_faster == 1'b1 && vc == 1, "R2 set before tie", ref_faster, 1);
        pulse(1'b1, 1'b1);
        count_vld(6, vc);
        pulse(1'b1, 1'b1);
        count_vld(8, vc);
        chk(vc == 0, "R5 tie after set gives no strobe", vc, 0);
        chk(ref_faster == 1'b1, "R5 tie keeps flag", ref_faster, 1);

        // Sweep of steady periodic waves (R10, R5)
        for (int hr = 2; hr <= 6; hr++) begin
            for (int hu = 2; hu <= 6; hu++) begin
                do_reset();
                run_waves(hr, hu, 240, hr != hu, hr < hu, vc);
                if (hr == hu) begin
                    chk(locked == 1'b0, "R5 aligned equal periods never lock", locked, 0);
                end else begin
                    chk(vc > 0, "R10 decision made", vc, 1);
                    chk(ref_faster == (hr < hu), "R10 final flag", ref_faster, hr < hu);
                end
            end
        end

        // Dominance reversal without reset (R4)
        do_reset();
        run_waves(2, 5, 200, 1'b1, 1'b1, vc);
        chk(ref_faster == 1'b1, "R4 reference dominant", ref_faster, 1);
        run_waves(8, 5, 300, 1'b0, 1'b0, vc);
        chk(ref_faster == 1'b0, "R4 flag follows reversal", ref_faster, 0);
        chk(locked == 1'b1, "R7 lock kept through reversal", locked, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule